// File: doc/BRIEF.md
# Flexible Second Operand Generator

This block forms the second operand of a data-processing operation, together with the shifter carry and a flag telling the flag logic whether that carry should be written. It works in one of two modes. In constant mode a 12-bit immediate field is expanded into a 32-bit word. The word is either an 8-bit value with its top bit forced to one and rotated within the word, or a byte copied into a fixed pattern of byte lanes. In register mode a 32-bit register value passes through unchanged or takes one immediate-count shift: logical left or arithmetic right.

The operand is computed in one combinational stage and registered once. Results therefore appear on the outputs one clock after the inputs are presented. The decoder drives the mode, the immediate, the shift controls, the current carry flag and the flag-setting indication. The ALU takes the registered operand, carry and carry-write enable. An error output marks encodings whose meaning is unpredictable.

Top module: `fop_operand_gen`

## Requirements
- R1: In constant mode with imm12[11:10] = 00, the byte B = imm12[7:0] is placed by imm12[9:8]: 00 gives 0x000000B, 01 gives B in bytes 0 and 2, 10 gives B in bytes 1 and 3, 11 gives B in all four bytes.
- R2: In constant mode with imm12[11:10] not 00, the operand is the 8-bit value {1, imm12[6:0]}, zero-extended to 32 bits and rotated right by imm12[11:7].
- R3: bad_enc_o is high in constant mode exactly when imm12[11:10] = 00, imm12[9:8] is not 00 and imm12[7:0] = 0.
- R4: For the rotated constant form with set_flags_i high and a value above 255, carry_wr_o is high and carry_o equals bit 31 of the operand.
- R5: Whenever carry_wr_o is low, carry_o equals carry_i. Every replicated constant form keeps carry_wr_o low.
- R6: carry_wr_o is never high unless set_flags_i was high.
- R7: In register mode with shift_kind_i = 01 (logical left) and shift_amt_i n in 1..31, the operand is rm shifted left by n with zero fill. The shifter carry is rm bit (32-n).
- R8: In register mode with shift_kind_i = 10 (arithmetic right) and n in 1..32, the operand is rm shifted right by n with copies of bit 31 filling the vacated bits. The shifter carry is rm bit (n-1). For n = 32, every result bit and the carry equal rm bit 31.
- R9: In register mode, shift_kind_i = 11, a logical-left amount outside 1..31 or an arithmetic-right amount outside 1..32 raises bad_enc_o. In that case the operand is rm unchanged, carry_o equals carry_i and carry_wr_o is low.
- R10: All outputs are zero while rst_n is low. After reset, each output reflects the inputs present at the previous rising clock edge and does not change between edges.
- R11: In register mode with shift_kind_i = 00, the operand is rm unchanged, shift_amt_i is ignored, carry_o equals carry_i, and carry_wr_o and bad_enc_o are low.
- R12: For an applied register shift (R7, R8) with set_flags_i high, carry_wr_o is high and carry_o is the shifter carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_reg_i | input | 1 | 1 selects register mode, 0 selects constant mode |
| imm12_i | input | 12 | Encoded immediate field |
| rm_i | input | 32 | Register operand value |
| shift_kind_i | input | 2 | 00 none, 01 logical left, 10 arithmetic right, 11 reserved |
| shift_amt_i | input | 6 | Immediate shift count |
| carry_i | input | 1 | Current carry flag |
| set_flags_i | input | 1 | The operation updates flags |
| operand_o | output | 32 | Registered second operand |
| carry_o | output | 1 | Registered carry result |
| carry_wr_o | output | 1 | Registered carry-write enable |
| bad_enc_o | output | 1 | Registered unpredictable-encoding flag |

## Verification
The block holds no state beyond its single output register. A wrong value in that register, or a wrong combinational path feeding it, shows on the outputs exactly one clock after the offending inputs, and it lasts only that one cycle. Every check therefore compares the outputs one edge after driving the inputs. All 4096 immediate encodings are swept so that each rotation and replication lane is observed. Shift cases cover the amount limits 1, 31 and 32 together with the out-of-range values around them, where a faulty carry-bit index or fill would appear first.

// File: rtl/fop_pkg.sv
package fop_pkg;

    localparam int WORD_W  = 32;
    localparam int BYTE_W  = 8;
    localparam int IMM_W   = 12;
    localparam int LANES   = WORD_W / BYTE_W;
    localparam int AMT_W   = $clog2(WORD_W) + 1;
    localparam int ROT_W   = $clog2(WORD_W);
    localparam int EXT_W   = 2 * WORD_W + 1;

    localparam logic [AMT_W-1:0] AMT_ONE     = AMT_W'(1);
    localparam logic [AMT_W-1:0] AMT_LSL_MAX = AMT_W'(WORD_W - 1);
    localparam logic [AMT_W-1:0] AMT_ASR_MAX = AMT_W'(WORD_W);

    typedef enum logic [1:0] {
        SHK_NONE = 2'b00,
        SHK_LSL  = 2'b01,
        SHK_ASR  = 2'b10,
        SHK_RSVD = 2'b11
    } shift_kind_e;

    typedef struct packed {
        logic [WORD_W-1:0] operand;
        logic              carry;
        logic              carry_wr;
        logic              bad_enc;
    } fop_out_t;

    typedef struct packed {
        fop_out_t res;
        logic     vld;
    } fop_state_t;

endpackage

// File: rtl/fop_const_expand.sv
module fop_const_expand
    import fop_pkg::*;
(
    input  logic [IMM_W-1:0]  imm12_i,
    output logic [WORD_W-1:0] value_o,
    output logic              rotated_o,
    output logic              above_byte_o,
    output logic              bad_o
);

    logic [BYTE_W-1:0]   pat_byte;
    logic [1:0]          pat_sel;
    logic [LANES-1:0]    lane_en;
    logic [WORD_W-1:0]   rep_val;
    logic [WORD_W-1:0]   rot_seed;
    logic [ROT_W-1:0]    rot_amt;
    logic [2*WORD_W-1:0] rot_dbl;
    logic [WORD_W-1:0]   rot_val;

    assign pat_byte = imm12_i[BYTE_W-1:0];
    assign pat_sel  = imm12_i[9:8];

    // lane enables of the replicated patterns
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g == 0) begin : g_base
            assign lane_en[g] = (pat_sel != 2'b10);
        end else if ((g % 2) == 0) begin : g_even
            assign lane_en[g] = pat_sel[0];
        end else begin : g_odd
            assign lane_en[g] = pat_sel[1];
        end
        assign rep_val[g*BYTE_W +: BYTE_W] = lane_en[g] ? pat_byte : '0;
    end

    // rotated form: top bit of the byte forced to one
    assign rot_seed = {{(WORD_W-BYTE_W){1'b0}}, 1'b1, imm12_i[BYTE_W-2:0]};
    assign rot_amt  = imm12_i[IMM_W-1 -: ROT_W];
    assign rot_dbl  = {rot_seed, rot_seed} >> rot_amt;
    assign rot_val  = rot_dbl[WORD_W-1:0];

    always_comb begin
        rotated_o    = (imm12_i[11:10] != 2'b00);
        value_o      = rotated_o ? rot_val : rep_val;
        above_byte_o = |value_o[WORD_W-1:BYTE_W];
        bad_o        = !rotated_o && (pat_sel != 2'b00) && (pat_byte == '0);
    end

endmodule

// File: rtl/fop_reg_shift.sv
module fop_reg_shift
    import fop_pkg::*;
(
    input  logic [WORD_W-1:0] rm_i,
    input  shift_kind_e       kind_i,
    input  logic [AMT_W-1:0]  amt_i,
    output logic [WORD_W-1:0] res_o,
    output logic              carry_o,
    output logic              applied_o,
    output logic              illegal_o
);

    logic [EXT_W-1:0] lsl_ext;
    logic [EXT_W-1:0] asr_ext;
    logic             lsl_ok;
    logic             asr_ok;

    // zero-extended word shifted up; bit WORD_W is the last bit shifted out
    assign lsl_ext = {{(WORD_W+1){1'b0}}, rm_i} << amt_i;
    // sign-extended word with a guard bit; bit 0 is the last bit shifted out
    assign asr_ext = {{WORD_W{rm_i[WORD_W-1]}}, rm_i, 1'b0} >> amt_i;

    assign lsl_ok = (amt_i >= AMT_ONE) && (amt_i <= AMT_LSL_MAX);
    assign asr_ok = (amt_i >= AMT_ONE) && (amt_i <= AMT_ASR_MAX);

    always_comb begin
        res_o     = rm_i;
        carry_o   = 1'b0;
        applied_o = 1'b0;
        illegal_o = 1'b0;
        unique case (kind_i)
            SHK_NONE: ;
            SHK_LSL: begin
                if (lsl_ok) begin
                    res_o     = lsl_ext[WORD_W-1:0];
                    carry_o   = lsl_ext[WORD_W];
                    applied_o = 1'b1;
                end else begin
                    illegal_o = 1'b1;
                end
            end
            SHK_ASR: begin
                if (asr_ok) begin
                    res_o     = asr_ext[WORD_W:1];
                    carry_o   = asr_ext[0];
                    applied_o = 1'b1;
                end else begin
                    illegal_o = 1'b1;
                end
            end
            default: illegal_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/fop_operand_gen.sv
module fop_operand_gen
    import fop_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_reg_i,
    input  logic [IMM_W-1:0]  imm12_i,
    input  logic [WORD_W-1:0] rm_i,
    input  logic [1:0]        shift_kind_i,
    input  logic [AMT_W-1:0]  shift_amt_i,
    input  logic              carry_i,
    input  logic              set_flags_i,
    output logic [WORD_W-1:0] operand_o,
    output logic              carry_o,
    output logic              carry_wr_o,
    output logic              bad_enc_o
);

    logic [WORD_W-1:0] cx_val;
    logic              cx_rot;
    logic              cx_big;
    logic              cx_bad;
    logic [WORD_W-1:0] sh_res;
    logic              sh_carry;
    logic              sh_applied;
    logic              sh_illegal;
    shift_kind_e       kind;

    fop_state_t st_d;
    fop_state_t st_q;

    assign kind = shift_kind_e'(shift_kind_i);

    fop_const_expand u_const (
        .imm12_i      (imm12_i),
        .value_o      (cx_val),
        .rotated_o    (cx_rot),
        .above_byte_o (cx_big),
        .bad_o        (cx_bad)
    );

    fop_reg_shift u_shift (
        .rm_i      (rm_i),
        .kind_i    (kind),
        .amt_i     (shift_amt_i),
        .res_o     (sh_res),
        .carry_o   (sh_carry),
        .applied_o (sh_applied),
        .illegal_o (sh_illegal)
    );

    always_comb begin
        logic upd;
        logic newc;
        st_d     = st_q;
        st_d.vld = 1'b1;
        if (mode_reg_i) begin
            st_d.res.operand = sh_res;
            upd              = set_flags_i && sh_applied;
            newc             = sh_carry;
            st_d.res.bad_enc = sh_illegal;
        end else begin
            st_d.res.operand = cx_val;
            upd              = set_flags_i && cx_rot && cx_big;
            newc             = cx_val[WORD_W-1];
            st_d.res.bad_enc = cx_bad;
        end
        st_d.res.carry_wr = upd;
        st_d.res.carry    = upd ? newc : carry_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign operand_o  = st_q.res.operand;
    assign carry_o    = st_q.res.carry;
    assign carry_wr_o = st_q.res.carry_wr;
    assign bad_enc_o  = st_q.res.bad_enc;

    // constant path
    p_rep_all_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_reg_i && imm12_i[11:8] == 4'b0011) |->
        (cx_val[31:24] == imm12_i[7:0] && cx_val[23:16] == imm12_i[7:0] &&
         cx_val[15:8] == imm12_i[7:0] && cx_val[7:0] == imm12_i[7:0]));

    p_bad_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_reg_i && cx_bad) |-> (cx_val == '0));

    p_rot_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vld && carry_wr_o && !$past(mode_reg_i)) |-> (carry_o == operand_o[WORD_W-1]));

    // carry handling
    p_carry_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vld && !carry_wr_o) |-> (carry_o == $past(carry_i)));

    p_wr_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vld && carry_wr_o) |-> $past(set_flags_i));

    // register path
    p_lsl_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_reg_i && sh_applied && kind == SHK_LSL) |->
        ((sh_res & ((32'd1 << shift_amt_i) - 32'd1)) == '0));

    p_asr_sign_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_reg_i && sh_applied && kind == SHK_ASR) |-> (sh_res[WORD_W-1] == rm_i[WORD_W-1]));

    p_bad_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vld && bad_enc_o && $past(mode_reg_i)) |->
        (operand_o == $past(rm_i) && !carry_wr_o));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vld && $stable(st_d)) |=> (st_q == $past(st_q)));

endmodule

// File: tb/fop_operand_gen_tb_top.sv
`timescale 1ns/1ps
module fop_operand_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_reg = 1'b0;
    logic [11:0] imm12 = '0;
    logic [31:0] rm = '0;
    logic [1:0]  kind = '0;
    logic [5:0]  amt = '0;
    logic        cin = 1'b0;
    logic        sf = 1'b0;
    logic [31:0] operand;
    logic        carry;
    logic        carry_wr;
    logic        bad_enc;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fop_operand_gen dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_reg_i   (mode_reg),
        .imm12_i      (imm12),
        .rm_i         (rm),
        .shift_kind_i (kind),
        .shift_amt_i  (amt),
        .carry_i      (cin),
        .set_flags_i  (sf),
        .operand_o    (operand),
        .carry_o      (carry),
        .carry_wr_o   (carry_wr),
        .bad_enc_o    (bad_enc)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic m, input logic [11:0] im, input logic [31:0] r,
                         input logic [1:0] k, input logic [5:0] a,
                         input logic c, input logic f);
        @(negedge clk);
        mode_reg = m; imm12 = im; rm = r; kind = k; amt = a; cin = c; sf = f;
        @(negedge clk);
    endtask

    function automatic logic [31:0] ref_const(input logic [11:0] im);
        logic [31:0] v;
        logic [7:0]  b;
        b = im[7:0];
        if (im[11:10] != 2'b00) begin
            v = {24'h0, 1'b1, im[6:0]};
            for (int k = 0; k < int'(im[11:7]); k++) v = {v[0], v[31:1]};
        end else begin
            case (im[9:8])
                2'b00:   v = {24'h0, b};
                2'b01:   v = {8'h0, b, 8'h0, b};
                2'b10:   v = {b, 8'h0, b, 8'h0};
                default: v = {b, b, b, b};
            endcase
        end
        return v;
    endfunction

    task automatic t_reset();
        mode_reg = 1'b1; rm = 32'hFFFF_FFFF; kind = 2'b10; amt = 6'd4; cin = 1'b1; sf = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10", "reset operand", operand, 32'h0);
        chk("R10", "reset carry", {31'h0, carry}, 32'h0);
        chk("R10", "reset carry_wr", {31'h0, carry_wr}, 32'h0);
        chk("R10", "reset bad_enc", {31'h0, bad_enc}, 32'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_const_sweep();
        for (int i = 0; i < 4096; i++) begin
            logic [11:0] im;
            logic        f, c, rot, ewr, ec, ebad;
            logic [31:0] ev;
            im = 12'(i);
            f = (i % 3) != 0;
            c = i[1] ^ i[6];
            drive(1'b0, im, 32'hDEAD_BEEF, 2'b01, 6'd3, c, f);
            ev   = ref_const(im);
            rot  = im[11:10] != 2'b00;
            ewr  = f && rot && (ev > 32'd255);
            ec   = ewr ? ev[31] : c;
            ebad = !rot && im[9:8] != 2'b00 && im[7:0] == 8'h00;
            if (rot) chk("R2", "rotated value", operand, ev);
            else     chk("R1", "replicated value", operand, ev);
            if (rot) chk("R4", "const carry_wr", {31'h0, carry_wr}, {31'h0, ewr});
            else     chk("R5", "rep carry_wr", {31'h0, carry_wr}, 32'h0);
            if (ewr) chk("R4", "const carry", {31'h0, carry}, {31'h0, ec});
            else     chk("R5", "const carry hold", {31'h0, carry}, {31'h0, c});
            if (!f)  chk("R6", "no flags no write", {31'h0, carry_wr}, 32'h0);
            chk("R3", "const bad_enc", {31'h0, bad_enc}, {31'h0, ebad});
        end
    endtask

    task automatic t_lsl();
        for (int i = 0; i < 300; i++) begin
            logic [31:0] r, ev;
            logic [5:0]  n;
            logic        f, c, ec;
            r = $urandom;
            n = (i < 2) ? ((i == 0) ? 6'd1 : 6'd31) : 6'(1 + ($urandom % 31));
            f = i[0]; c = i[1];
            drive(1'b1, 12'h0, r, 2'b01, n, c, f);
            ev = r << n;
            ec = f ? r[32 - int'(n)] : c;
            chk("R7", "lsl value", operand, ev);
            chk("R12", "lsl carry_wr", {31'h0, carry_wr}, {31'h0, f});
            chk("R7", "lsl carry", {31'h0, carry}, {31'h0, ec});
            chk("R7", "lsl bad_enc", {31'h0, bad_enc}, 32'h0);
        end
    endtask

    task automatic t_asr();
        for (int i = 0; i < 300; i++) begin
            logic [31:0] r, ev;
            logic [5:0]  n;
            logic        f, c, ec;
            r = $urandom;
            if (i < 4) r[31] = i[0];
            n = (i < 4) ? ((i < 2) ? 6'd32 : 6'd1) : 6'(1 + ($urandom % 32));
            f = ~i[0] | i[2]; c = i[1];
            drive(1'b1, 12'h0, r, 2'b10, n, c, f);
            ev = (n == 6'd32) ? {32{r[31]}} : 32'($signed(r) >>> n);
            ec = f ? r[int'(n) - 1] : c;
            chk("R8", "asr value", operand, ev);
            chk("R12", "asr carry_wr", {31'h0, carry_wr}, {31'h0, f});
            chk("R8", "asr carry", {31'h0, carry}, {31'h0, ec});
        end
    endtask

    task automatic t_illegal();
        logic [1:0] ks [6] = '{2'b01, 2'b01, 2'b01, 2'b10, 2'b10, 2'b11};
        logic [5:0] ns [6] = '{6'd0, 6'd32, 6'd40, 6'd0, 6'd33, 6'd5};
        for (int i = 0; i < 6; i++) begin
            logic c;
            c = i[0];
            drive(1'b1, 12'hFFF, 32'h8123_4567, ks[i], ns[i], c, 1'b1);
            chk("R9", "illegal operand", operand, 32'h8123_4567);
            chk("R9", "illegal carry", {31'h0, carry}, {31'h0, c});
            chk("R9", "illegal carry_wr", {31'h0, carry_wr}, 32'h0);
            chk("R9", "illegal bad_enc", {31'h0, bad_enc}, 32'h1);
        end
    endtask

    task automatic t_unshifted();
        for (int i = 0; i < 8; i++) begin
            logic [31:0] r;
            logic        c;
            r = $urandom;
            c = i[0];
            drive(1'b1, 12'h123, r, 2'b00, 6'(i * 9), c, 1'b1);
            chk("R11", "none operand", operand, r);
            chk("R11", "none carry", {31'h0, carry}, {31'h0, c});
            chk("R11", "none carry_wr", {31'h0, carry_wr}, 32'h0);
            chk("R11", "none bad_enc", {31'h0, bad_enc}, 32'h0);
        end
    endtask

    task automatic t_latency();
        drive(1'b0, 12'h3A5, 32'h0, 2'b00, 6'd0, 1'b0, 1'b0);
        chk("R10", "first value", operand, 32'hA5A5_A5A5);
        mode_reg = 1'b1; rm = 32'h1357_9BDF; kind = 2'b00;
        #1;
        chk("R10", "no change before edge", operand, 32'hA5A5_A5A5);
        @(negedge clk);
        chk("R10", "change after edge", operand, 32'h1357_9BDF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R10 watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_latency();
        t_const_sweep();
        t_lsl();
        t_asr();
        t_illegal();
        t_unshifted();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule